// File: doc/BRIEF.md
# Hamming ECC Generator and Checker for 512-Byte Flash Chunks

This block protects one chunk of flash data (512 bytes by default) with a single-error-correcting, double-error-detecting Hamming code. Data arrives one byte per cycle while `byte_vld` is high. Every data bit has a 12-bit address: the byte index times eight plus the bit number. For each address bit, two parity planes are kept. The result is a 24-bit code that is inverted before it leaves the block, so a fully erased chunk (all 0xFF) yields an all-ones code. Such a code matches the contents of an erased spare area.

Software reads the code on `code_out`. It then pulses `code_rd`, which clears the accumulator for the next chunk. `ecc_start` discards a partial chunk in the same way.

A separate compare path takes a stored code and a freshly computed code and classifies their difference. The possible results are:
- no error;
- a single flipped data bit, given by byte index and bit index;
- a single flipped bit inside the stored code itself;
- an uncorrectable error.

Flipping the faulty bit in a buffer is left to the caller.

Top module: `nand_hamming_ecc`

## Requirements
- R1: A data bit at address A = byte_index*8 + bit (bit 0 = LSB of the byte) toggles high-plane parity bit k when A[k]=1 and low-plane parity bit k when A[k]=0, for k = 0..11.
- R2: `code_out` equals the bitwise inverse of {high plane, low plane}: bits 23:12 hold the inverted high plane and bits 11:0 the inverted low plane. Byte n of the code is bits 8n+7:8n, least significant byte first.
- R3: After reset, after a clear, and after a chunk of all 0xFF bytes, `code_out` is 24'hFFFFFF.
- R4: `code_out` shows the finished code up to the edge where `code_rd` is sampled high. At that edge the planes and the byte index are cleared.
- R5: `ecc_start` clears the planes and the byte index in the same way, discarding any partial chunk.
- R6: A byte presented in the same cycle as `code_rd` or `ecc_start` is accumulated as byte 0 of the new chunk.
- R7: A compare request on `cmp_vld` gives its result one cycle later with `res_vld` high. `res_vld` is low in every other cycle.
- R8: If `cmp_stored` XOR `cmp_fresh` is zero, `res_kind` is 0 (clean).
- R9: If the difference D has D[11:0] XOR D[23:12] = 12'hFFF, `res_kind` is 1 (data fix), `res_byte` = D[23:15] and `res_bit` = D[14:12], provided the byte index is below CHUNK_BYTES.
- R10: A difference with the fix pattern whose byte index is CHUNK_BYTES or more gives `res_kind` 3 (uncorrectable).
- R11: A difference with exactly one bit set gives `res_kind` 2 (code-only error).
- R12: Any other nonzero difference gives `res_kind` 3. `res_byte` and `res_bit` are zero whenever `res_kind` is not 1.
- R13: Cycles with `byte_vld`, `code_rd` and `ecc_start` all low leave `code_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_start | input | 1 | Discard partial chunk and restart accumulation |
| code_rd | input | 1 | Code consumed; clear accumulator |
| byte_vld | input | 1 | Data byte valid this cycle |
| byte_in | input | 8 | Data byte |
| code_out | output | 24 | Inverted packed Hamming code of bytes so far |
| cmp_vld | input | 1 | Compare request |
| cmp_stored | input | 24 | Code read back from the spare area |
| cmp_fresh | input | 24 | Code computed over the data just read |
| res_vld | output | 1 | Compare result valid |
| res_kind | output | 2 | 0 clean, 1 data fix, 2 code-only, 3 uncorrectable |
| res_byte | output | 9 | Byte index of the faulty bit |
| res_bit | output | 3 | Bit index of the faulty bit |

## Verification
Clearing the accumulator and taking in a data byte can fall in the same cycle. This happens when the consumer reads a finished code while the next chunk's first byte is already on the bus. The bench provokes it by raising `code_rd` and `byte_vld` together. It checks `code_out` just before that edge against the model of the old chunk. After the edge it checks `code_out` against a model holding only the new byte at address 0. After streaming the remaining 511 bytes it checks the full chunk. A second instance with a 256-byte chunk reaches the out-of-range fix case.

// File: rtl/nand_ecc_pkg.sv
// Package: shared widths and the compare verdict encoding for the
// flash Hamming ECC block. Assumes a 4096-bit addressable chunk at most.
package nand_ecc_pkg;
    localparam int HALF_W     = 12;          // parity bits per plane
    localparam int CODE_W     = 2 * HALF_W;  // packed code width
    localparam int BIT_IDX_W  = 3;           // bit within a byte
    localparam int BYTE_IDX_W = HALF_W - BIT_IDX_W;

    typedef enum logic [1:0] {
        VERD_CLEAN     = 2'd0,
        VERD_DATA_FIX  = 2'd1,
        VERD_CODE_ONLY = 2'd2,
        VERD_FATAL     = 2'd3
    } ecc_verdict_t;
endpackage

// File: rtl/ecc_accum.sv
// Module: ecc_accum
// Accumulates the two Hamming parity planes over a byte stream. Each bit
// address is {byte index, bit number}; address bit k routes the bit into
// the high plane (bit set) or the low plane (bit clear).
// Assumes CHUNK_BYTES <= 2**BYTE_IDX_W. A clear and a byte in the same
// cycle put that byte at index 0 of the new chunk.
module ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    output logic [HALF_W-1:0] hi_plane,
    output logic [HALF_W-1:0] lo_plane
);
    localparam logic [BYTE_IDX_W-1:0] LAST_IDX = BYTE_IDX_W'(CHUNK_BYTES - 1);

    logic [HALF_W-1:0]     hi_q, lo_q, hi_d, lo_d, base_hi, base_lo;
    logic [BYTE_IDX_W-1:0] cnt_q, cnt_d, base_cnt;
    logic [HALF_W-1:0]     bit_addr;

    // Next-state: optional clear, then fold in the current byte.
    always_comb begin
        base_hi  = clr ? '0 : hi_q;
        base_lo  = clr ? '0 : lo_q;
        base_cnt = clr ? '0 : cnt_q;
        hi_d     = base_hi;
        lo_d     = base_lo;
        cnt_d    = base_cnt;
        bit_addr = '0;
        if (byte_vld) begin
            for (int b = 0; b < 8; b++) begin
                bit_addr = {base_cnt, BIT_IDX_W'(b)};
                for (int k = 0; k < HALF_W; k++) begin
                    if (bit_addr[k]) hi_d[k] = hi_d[k] ^ byte_in[b];
                    else             lo_d[k] = lo_d[k] ^ byte_in[b];
                end
            end
            cnt_d = (base_cnt == LAST_IDX) ? '0 : base_cnt + 1'b1;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            cnt_q <= '0;
        end else begin
            hi_q  <= hi_d;
            lo_q  <= lo_d;
            cnt_q <= cnt_d;
        end
    end

    assign hi_plane = hi_q;
    assign lo_plane = lo_q;

    // R4 / R5: a clear without data leaves empty planes and index 0.
    p_clear_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !byte_vld) |=> (hi_q == '0 && lo_q == '0 && cnt_q == '0));

    // R6: a byte taken with the clear becomes byte 0, so the index moves to 1.
    p_first_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && byte_vld) |=> (cnt_q == BYTE_IDX_W'(1 % CHUNK_BYTES)));

    // R13: idle cycles keep all state.
    p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !byte_vld) |=> ($stable(hi_q) && $stable(lo_q) && $stable(cnt_q)));
endmodule

// File: rtl/ecc_compare.sv
// Module: ecc_compare
// Classifies the difference between a stored and a fresh code, one
// register stage deep. Assumes the code layout {high plane, low plane}.
module ecc_compare
    import nand_ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmp_vld,
    input  logic [CODE_W-1:0]     stored,
    input  logic [CODE_W-1:0]     fresh,
    output logic                  res_vld,
    output logic [1:0]            res_kind,
    output logic [BYTE_IDX_W-1:0] res_byte,
    output logic [BIT_IDX_W-1:0]  res_bit
);
    localparam logic [BYTE_IDX_W:0] IDX_LIM = (BYTE_IDX_W + 1)'(CHUNK_BYTES);

    logic [CODE_W-1:0]     diff;
    logic [HALF_W-1:0]     sym;
    logic [BYTE_IDX_W-1:0] idx;
    logic [BIT_IDX_W-1:0]  bsel;
    logic                  single;
    ecc_verdict_t          kind_d;
    logic [BYTE_IDX_W-1:0] byte_d;
    logic [BIT_IDX_W-1:0]  bit_d;

    assign diff   = stored ^ fresh;
    assign sym    = diff[HALF_W-1:0] ^ diff[CODE_W-1:HALF_W];
    assign idx    = diff[CODE_W-1:CODE_W-BYTE_IDX_W];
    assign bsel   = diff[HALF_W+BIT_IDX_W-1:HALF_W];
    assign single = (diff & (diff - 1'b1)) == '0;

    // Verdict in priority order: clean, data fix, code-only, fatal.
    always_comb begin
        kind_d = VERD_FATAL;
        byte_d = '0;
        bit_d  = '0;
        if (diff == '0) begin
            kind_d = VERD_CLEAN;
        end else if (sym == '1) begin
            if ({1'b0, idx} < IDX_LIM) begin
                kind_d = VERD_DATA_FIX;
                byte_d = idx;
                bit_d  = bsel;
            end
        end else if (single) begin
            kind_d = VERD_CODE_ONLY;
        end
    end

    // Result register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld  <= 1'b0;
            res_kind <= VERD_CLEAN;
            res_byte <= '0;
            res_bit  <= '0;
        end else begin
            res_vld <= cmp_vld;
            if (cmp_vld) begin
                res_kind <= kind_d;
                res_byte <= byte_d;
                res_bit  <= bit_d;
            end
        end
    end

    // R7: a result follows every request, and only a request.
    p_res_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_vld |=> res_vld);
    p_res_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_vld |=> !res_vld);

    // R11: a lone flipped code bit is reported as code-only.
    p_code_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_vld && $countones(stored ^ fresh) == 1) |=> (res_kind == VERD_CODE_ONLY));

    // R12: location fields stay zero unless a data fix is reported.
    p_fields_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind != VERD_DATA_FIX) |-> (res_byte == '0 && res_bit == '0));

    // R10: a reported fix always lies inside the chunk.
    p_fix_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && res_kind == VERD_DATA_FIX) |-> ({1'b0, res_byte} < IDX_LIM));
endmodule

// File: rtl/nand_hamming_ecc.sv
// Module: nand_hamming_ecc
// Top of the flash chunk Hamming ECC: a streaming parity accumulator
// whose inverted planes form the 24-bit code, and an independent
// compare path. Assumes code_rd is pulsed once per consumed code.
module nand_hamming_ecc
    import nand_ecc_pkg::*;
#(
    parameter int CHUNK_BYTES = 512
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ecc_start,
    input  logic                  code_rd,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_in,
    output logic [CODE_W-1:0]     code_out,
    input  logic                  cmp_vld,
    input  logic [CODE_W-1:0]     cmp_stored,
    input  logic [CODE_W-1:0]     cmp_fresh,
    output logic                  res_vld,
    output logic [1:0]            res_kind,
    output logic [BYTE_IDX_W-1:0] res_byte,
    output logic [BIT_IDX_W-1:0]  res_bit
);
    logic [HALF_W-1:0] hi_plane, lo_plane;
    logic              clr;

    // Reading the code and restarting both empty the accumulator.
    assign clr = code_rd | ecc_start;

    ecc_accum #(.CHUNK_BYTES(CHUNK_BYTES)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .hi_plane (hi_plane),
        .lo_plane (lo_plane)
    );

    // Packed and inverted so an erased chunk reads as all ones.
    assign code_out = ~{hi_plane, lo_plane};

    ecc_compare #(.CHUNK_BYTES(CHUNK_BYTES)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_vld  (cmp_vld),
        .stored   (cmp_stored),
        .fresh    (cmp_fresh),
        .res_vld  (res_vld),
        .res_kind (res_kind),
        .res_byte (res_byte),
        .res_bit  (res_bit)
    );

    // R3: directly after reset the code reads all ones.
    p_reset_ones_r3: assert property (@(posedge clk)
        !rst_n |=> (code_out == '1));
endmodule

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ecc_start = 1'b0, code_rd = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic [23:0] code_out;
    logic        cmp_vld = 1'b0;
    logic [23:0] cmp_stored = '0, cmp_fresh = '0;
    logic        res_vld;
    logic [1:0]  res_kind;
    logic [8:0]  res_byte;
    logic [2:0]  res_bit;

    logic        s_cmp_vld = 1'b0;
    logic [23:0] s_stored = '0, s_fresh = '0;
    logic [23:0] s_code;
    logic        s_res_vld;
    logic [1:0]  s_res_kind;
    logic [8:0]  s_res_byte;
    logic [2:0]  s_res_bit;

    int checks = 0, errors = 0;
    logic [7:0]  mem [512];
    logic [23:0] code_a, code_b;

    always #4 clk = ~clk;

    nand_hamming_ecc u_dut (
        .clk(clk), .rst_n(rst_n), .ecc_start(ecc_start), .code_rd(code_rd),
        .byte_vld(byte_vld), .byte_in(byte_in), .code_out(code_out),
        .cmp_vld(cmp_vld), .cmp_stored(cmp_stored), .cmp_fresh(cmp_fresh),
        .res_vld(res_vld), .res_kind(res_kind), .res_byte(res_byte), .res_bit(res_bit)
    );

    nand_hamming_ecc #(.CHUNK_BYTES(256)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .ecc_start(1'b0), .code_rd(1'b0),
        .byte_vld(1'b0), .byte_in(8'h00), .code_out(s_code),
        .cmp_vld(s_cmp_vld), .cmp_stored(s_stored), .cmp_fresh(s_fresh),
        .res_vld(s_res_vld), .res_kind(s_res_kind), .res_byte(s_res_byte), .res_bit(s_res_bit)
    );

    // Compare vectors: difference, expected kind, byte, bit.
    localparam int NV = 8;
    localparam logic [23:0] V_DIFF [NV] = '{24'h000000, 24'h02BFD4, 24'hFFF000, 24'h000FFF,
                                            24'h000010, 24'h800000, 24'h000003, 24'h02B02B};
    localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd3};
    localparam logic [8:0]  V_BYTE [NV] = '{9'd0, 9'd5, 9'd511, 9'd0, 9'd0, 9'd0, 9'd0, 9'd0};
    localparam logic [2:0]  V_BIT  [NV] = '{3'd0, 3'd3, 3'd7, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((i * 37) + (seed * 11) + (i >> 3) + (i * i * seed));
    endfunction

    // Model per R1/R2: planes from bit addresses, then inverted.
    function automatic logic [23:0] model(input int n, input int flip_addr);
        logic [11:0] hi = '0, lo = '0;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                logic [11:0] a = 12'(i * 8 + b);
                logic v = mem[i][b] ^ (int'(a) == flip_addr);
                for (int k = 0; k < 12; k++) begin
                    if (a[k]) hi[k] = hi[k] ^ v;
                    else      lo[k] = lo[k] ^ v;
                end
            end
        end
        return ~{hi, lo};
    endfunction

    task automatic stream(input int from, input int to, input int flip_addr);
        for (int i = from; i < to; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_in  = mem[i];
            for (int b = 0; b < 8; b++)
                if (i * 8 + b == flip_addr) byte_in[b] = ~byte_in[b];
        end
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); code_rd = 1'b1;
        @(negedge clk); code_rd = 1'b0;
    endtask

    task automatic compare(input logic [23:0] st, input logic [23:0] fr);
        @(negedge clk); cmp_vld = 1'b1; cmp_stored = st; cmp_fresh = fr;
        @(negedge clk); cmp_vld = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 / R7: reset state
        chk(code_out == 24'hFFFFFF, "R3 reset code", 32'(code_out), 32'hFFFFFF);
        chk(res_vld == 1'b0, "R7 no result after reset", 32'(res_vld), 0);

        // R8 R9 R11 R12: vector table on the compare path
        for (int v = 0; v < NV; v++) begin
            compare(24'h5A3C96 ^ V_DIFF[v], 24'h5A3C96);
            chk(res_vld == 1'b1, "R7 result valid", 32'(res_vld), 1);
            chk(res_kind == V_KIND[v], "R8/R9/R11/R12 kind", 32'(res_kind), 32'(V_KIND[v]));
            chk(res_byte == V_BYTE[v] && res_bit == V_BIT[v], "R9/R12 location",
                {res_byte, res_bit}, {V_BYTE[v], V_BIT[v]});
        end
        @(negedge clk);
        chk(res_vld == 1'b0, "R7 result one cycle only", 32'(res_vld), 0);

        // R10: 256-byte instance, address 2048 is beyond its chunk
        @(negedge clk); s_cmp_vld = 1'b1; s_stored = 24'h8007FF; s_fresh = 24'h0;
        @(negedge clk); s_cmp_vld = 1'b0;
        chk(s_res_kind == 2'd3, "R10 out of range fix", 32'(s_res_kind), 3);
        @(negedge clk); s_cmp_vld = 1'b1; s_stored = 24'h7FF800;
        @(negedge clk); s_cmp_vld = 1'b0;
        chk(s_res_kind == 2'd1 && s_res_byte == 9'd255 && s_res_bit == 3'd7, "R10 last in-range byte",
            {s_res_kind, s_res_byte, s_res_bit}, {2'd1, 9'd255, 3'd7});

        // R3: erased chunk
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        stream(0, 512, -1);
        chk(code_out == 24'hFFFFFF, "R3 erased chunk", 32'(code_out), 32'hFFFFFF);
        pulse_rd();

        // R1 R2: patterned chunk
        for (int i = 0; i < 512; i++) mem[i] = pat(1, i);
        stream(0, 512, -1);
        code_a = model(512, -1);
        chk(code_out == code_a, "R1/R2 pattern code", 32'(code_out), 32'(code_a));
        repeat (3) @(negedge clk);
        chk(code_out == code_a, "R13 idle keeps code", 32'(code_out), 32'(code_a));
        pulse_rd();
        chk(code_out == 24'hFFFFFF, "R4 cleared by read", 32'(code_out), 32'hFFFFFF);

        // R9 end to end: same data with one flipped bit (byte 300, bit 6)
        stream(0, 512, 300 * 8 + 6);
        code_b = model(512, 300 * 8 + 6);
        chk(code_out == code_b, "R1 flipped chunk code", 32'(code_out), 32'(code_b));
        compare(code_a, code_out);
        chk(res_kind == 2'd1 && res_byte == 9'd300 && res_bit == 3'd6, "R9 end-to-end fix",
            {res_kind, res_byte, res_bit}, {2'd1, 9'd300, 3'd6});
        pulse_rd();

        // R5: restart discards a partial chunk
        for (int i = 0; i < 512; i++) mem[i] = pat(2, i);
        stream(0, 10, -1);
        @(negedge clk); ecc_start = 1'b1;
        @(negedge clk); ecc_start = 1'b0;
        chk(code_out == 24'hFFFFFF, "R5 restart clears", 32'(code_out), 32'hFFFFFF);
        stream(0, 512, -1);
        code_a = model(512, -1);
        chk(code_out == code_a, "R5 code after restart", 32'(code_out), 32'(code_a));

        // R4 R6: read and first byte of the next chunk in the same cycle
        for (int i = 0; i < 512; i++) mem[i] = pat(3, i);
        @(negedge clk);
        chk(code_out == code_a, "R4 code held until read", 32'(code_out), 32'(code_a));
        code_rd = 1'b1; byte_vld = 1'b1; byte_in = mem[0];
        @(negedge clk);
        code_rd = 1'b0; byte_vld = 1'b0;
        code_b = model(1, -1);
        chk(code_out == code_b, "R6 byte with read is byte 0", 32'(code_out), 32'(code_b));
        stream(1, 512, -1);
        code_b = model(512, -1);
        chk(code_out == code_b, "R6 full chunk after overlap", 32'(code_out), 32'(code_b));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule